// File: doc/BRIEF.md
# Byte-Order-Selectable Memory Access Unit

This unit sits between a 32-bit core and a byte-addressed on-chip RAM. It serves instruction fetches and data loads and stores of one, two or four bytes, checks every access against the RAM size, and builds the byte lanes that go to and come back from the RAM. A single control bit, held in a CSR, selects little- or big-endian ordering for data accesses. Instruction fetches ignore that bit and are always assembled little-endian.

The RAM side is a synchronous byte-lane port: `ram_addr` is the first byte A of the access, lane k of `ram_wdata`, `ram_be` and `ram_rdata` carries the byte at A+k, and read data arrives one cycle after `ram_en`. Each cycle the unit accepts one request. A data request wins over a fetch request in the same cycle, and the fetch is flagged as stalled. A response appears the cycle after its request. An access whose last byte lies outside the RAM halts the unit. The unit then reports the faulting address and the PC, and it serves nothing more until reset or a program reload.

The control state machine has four states. ST_READY is idle. ST_LOAD_RSP means a load response is on `ls_rdata`. ST_FETCH_RSP means a fetch response is on `fetch_rdata`. ST_HALTED means an access went out of range. From ST_READY, ST_LOAD_RSP or ST_FETCH_RSP the machine moves as follows:
- An accepted out-of-range access goes to ST_HALTED.
- An accepted in-range load goes to ST_LOAD_RSP.
- An accepted in-range fetch goes to ST_FETCH_RSP.
- An accepted store, or no request, goes to ST_READY.

ST_HALTED holds until `reload`, which goes to ST_READY. Reset also enters ST_READY.

Top module: `mem_order_unit`

## Requirements
- R1: After reset the ordering bit is clear (CSR 0x310 reads 0), `halt` is low and neither `ls_rvalid` nor `fetch_rvalid` is high.
- R2: With the ordering bit clear, a load of N bytes at A (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) returns the byte at A+i in bits [8i+7:8i], right-aligned, with all bits above 8N zero.
- R3: With the ordering bit set, a load of N bytes at A returns the byte at A+N-1-i in bits [8i+7:8i] (byte A most significant), upper bits zero.
- R4: With the ordering bit set, a store of N bytes at A writes bits [8i+7:8i] of `ls_wdata` to byte A+N-1-i; with it clear, to byte A+i.
- R5: A store of N bytes enables exactly N RAM lanes, and the bytes next to the addressed ones keep their values.
- R6: An instruction fetch returns the four bytes at A..A+3 in little-endian order whether the ordering bit is set or clear.
- R7: A write to CSR 0x310 sets the ordering bit from bit 5 of the write data. Reading 0x310 returns 0x20 when the bit is set and 0 otherwise. Every other bit reads zero and ignores writes.
- R8: Writes to any other CSR address, such as the read-only counters 0xC00–0xC02 and 0xC80–0xC82 or the machine ID registers 0xF11–0xF15, 0x300 and 0x301, change nothing, and those addresses read 0.
- R9: A write to 0x310 affects data accesses accepted from the next cycle on. A load accepted in the same cycle as the write uses the old ordering.
- R10: An access whose last byte A+N-1 is beyond RAM_BYTES-1 makes no RAM access. In the next cycle it raises `halt`, with `fault_addr` = A and `fault_pc` = the `pc` input at the time of the request.
- R11: While halted, requests get no response and cause no RAM access, and `halt` stays high.
- R12: A `reload` pulse clears the ordering bit and `halt`, and the unit serves requests again.
- R13: A response comes one cycle after its request. When `ls_req` and `fetch_req` are both high, the data request is served and `fetch_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | 1 | Program-load pulse; clears ordering bit and halt |
| pc | input | 32 | Current program counter, captured on a fault |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_stall | output | 1 | Fetch not taken this cycle (data request has priority) |
| fetch_rvalid | output | 1 | Fetch response valid |
| fetch_rdata | output | 32 | Fetched word, little-endian |
| ls_req | input | 1 | Data request |
| ls_we | input | 1 | 1 = store, 0 = load |
| ls_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = word |
| ls_addr | input | 32 | Data byte address |
| ls_wdata | input | 32 | Store data, right-aligned |
| ls_rvalid | output | 1 | Load response valid |
| ls_rdata | output | 32 | Load data, right-aligned, zero-filled |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr` |
| halt | output | 1 | Out-of-range access seen; unit stopped |
| fault_addr | output | 32 | Address of the faulting access |
| fault_pc | output | 32 | PC at the faulting access |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write |
| ram_addr | output | RAM_AW | First byte address of the access |
| ram_be | output | 4 | Lane write enables |
| ram_wdata | output | 32 | Lane write data |
| ram_rdata | input | 32 | Lane read data, one cycle after `ram_en` |

## Verification
A wrong ordering bit shows up on the very next data response or store: the lanes come back mirrored, or the wrong RAM bytes are written. A wrong ordering bit leaves fetch data unchanged, and that is itself the check for R6. A state machine stuck in a response state shows a spurious `ls_rvalid` or `fetch_rvalid` one cycle later. A lost halt shows up as RAM activity or a response after an out-of-range access, again within one cycle. A wrong size-to-lane decode shows up at once in the count of enabled RAM lanes, or in non-zero upper bits of a short load.

// File: rtl/mou_pkg.sv
package mou_pkg;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_LOAD_RSP  = 2'd1,
        ST_FETCH_RSP = 2'd2,
        ST_HALTED    = 2'd3
    } mou_state_e;

    localparam int unsigned LANES      = 4;
    localparam int unsigned DATA_W     = 8 * LANES;
    localparam int unsigned CNT_W      = $clog2(LANES) + 1;
    localparam logic [11:0] ORDER_CSR  = 12'h310;
    localparam int unsigned ORDER_BIT  = 5;

    function automatic logic [CNT_W-1:0] size_to_count(input logic [1:0] sz);
        unique case (sz)
            2'd0:    size_to_count = CNT_W'(1);
            2'd1:    size_to_count = CNT_W'(2);
            default: size_to_count = CNT_W'(LANES);
        endcase
    endfunction

endpackage

// File: rtl/byte_lane_order.sv
module byte_lane_order
    import mou_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              reverse,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            logic [CNT_W-1:0] src;
            if (reverse) begin
                src = nbytes - CNT_W'(1) - CNT_W'(i);
            end else begin
                src = CNT_W'(i);
            end
            if (CNT_W'(i) < nbytes) begin
                dout[8*i +: 8] = din[8*src[CNT_W-2:0] +: 8];
            end else begin
                dout[8*i +: 8] = 8'h00;
            end
        end
    end
endmodule

// File: rtl/addr_range_chk.sv
module addr_range_chk
    import mou_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 65536
) (
    input  logic [31:0]      addr,
    input  logic [CNT_W-1:0] nbytes,
    output logic             in_range
);
    localparam logic [32:0] LAST_BYTE = 33'(RAM_BYTES) - 33'd1;

    logic [32:0] last_addr;

    always_comb begin
        last_addr = {1'b0, addr} + 33'(nbytes) - 33'd1;
        in_range  = (last_addr <= LAST_BYTE);
    end
endmodule

// File: rtl/order_csr.sv
module order_csr
    import mou_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reload,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        big_endian
);
    logic hit;

    assign hit = (csr_addr == ORDER_CSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_endian <= 1'b0;
        end else if (reload) begin
            big_endian <= 1'b0;
        end else if (csr_we && hit) begin
            big_endian <= csr_wdata[ORDER_BIT];
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (hit) begin
            csr_rdata[ORDER_BIT] = big_endian;
        end
    end
endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit
    import mou_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 65536,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [31:0]       pc,
    input  logic              fetch_req,
    input  logic [31:0]       fetch_addr,
    output logic              fetch_stall,
    output logic              fetch_rvalid,
    output logic [31:0]       fetch_rdata,
    input  logic              ls_req,
    input  logic              ls_we,
    input  logic [1:0]        ls_size,
    input  logic [31:0]       ls_addr,
    input  logic [31:0]       ls_wdata,
    output logic              ls_rvalid,
    output logic [31:0]       ls_rdata,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              halt,
    output logic [31:0]       fault_addr,
    output logic [31:0]       fault_pc,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [3:0]        ram_be,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata
);
    mou_state_e       state_q, state_d;
    logic             big_endian;
    logic             sel_data, sel_fetch, accept, in_range, fault;
    logic [31:0]      req_addr;
    logic [CNT_W-1:0] req_count;
    logic [CNT_W-1:0] rsp_count_q;
    logic             rsp_big_q;
    logic [31:0]      store_lanes;
    logic [31:0]      load_lanes;
    logic [31:0]      fetch_lanes;
    logic [LANES:0]   lane_mask;

    order_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .big_endian (big_endian)
    );

    // Request selection: data side has priority over fetch.
    always_comb begin
        sel_data  = ls_req;
        sel_fetch = fetch_req && !ls_req;
        req_addr  = sel_data ? ls_addr : fetch_addr;
        req_count = sel_data ? size_to_count(ls_size) : CNT_W'(LANES);
        accept    = (state_q != ST_HALTED) && !reload && (sel_data || sel_fetch);
        fault     = accept && !in_range;
    end

    addr_range_chk #(.RAM_BYTES(RAM_BYTES)) u_range (
        .addr     (req_addr),
        .nbytes   (req_count),
        .in_range (in_range)
    );

    byte_lane_order u_store_order (
        .din     (ls_wdata),
        .nbytes  (req_count),
        .reverse (big_endian),
        .dout    (store_lanes)
    );

    byte_lane_order u_load_order (
        .din     (ram_rdata),
        .nbytes  (rsp_count_q),
        .reverse (rsp_big_q),
        .dout    (load_lanes)
    );

    byte_lane_order u_fetch_order (
        .din     (ram_rdata),
        .nbytes  (CNT_W'(LANES)),
        .reverse (1'b0),
        .dout    (fetch_lanes)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY, ST_LOAD_RSP, ST_FETCH_RSP: begin
                if (reload) begin
                    state_d = ST_READY;
                end else if (fault) begin
                    state_d = ST_HALTED;
                end else if (accept && sel_data && !ls_we) begin
                    state_d = ST_LOAD_RSP;
                end else if (accept && sel_fetch) begin
                    state_d = ST_FETCH_RSP;
                end else begin
                    state_d = ST_READY;
                end
            end
            ST_HALTED: begin
                if (reload) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // Response context and fault capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_count_q <= CNT_W'(LANES);
            rsp_big_q   <= 1'b0;
            fault_addr  <= '0;
            fault_pc    <= '0;
        end else begin
            if (accept && sel_data) begin
                rsp_count_q <= req_count;
                rsp_big_q   <= big_endian;
            end
            if (fault) begin
                fault_addr <= req_addr;
                fault_pc   <= pc;
            end
        end
    end

    // Outputs.
    always_comb begin
        lane_mask    = (LANES+1)'((1 << req_count) - 1);
        ram_en       = accept && in_range;
        ram_we       = ram_en && sel_data && ls_we;
        ram_addr     = req_addr[RAM_AW-1:0];
        ram_be       = ram_we ? lane_mask[LANES-1:0] : 4'h0;
        ram_wdata    = store_lanes;
        fetch_stall  = fetch_req && ls_req;
        halt         = (state_q == ST_HALTED);
        ls_rvalid    = (state_q == ST_LOAD_RSP);
        fetch_rvalid = (state_q == ST_FETCH_RSP);
        ls_rdata     = ls_rvalid ? load_lanes : 32'h0;
        fetch_rdata  = fetch_rvalid ? fetch_lanes : 32'h0;
    end
endmodule

// File: rtl/mou_checker.sv
module mou_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reload,
    input logic        fetch_req,
    input logic        fetch_stall,
    input logic        fetch_rvalid,
    input logic        ls_req,
    input logic        ls_we,
    input logic [1:0]  ls_size,
    input logic        ls_rvalid,
    input logic [11:0] csr_addr,
    input logic [31:0] csr_rdata,
    input logic        halt,
    input logic        ram_en,
    input logic        ram_we,
    input logic [3:0]  ram_be
);
    a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($countones(ram_be) == ((ls_size == 2'd0) ? 1 : (ls_size == 2'd1) ? 2 : 4)));

    a_r5_no_lanes_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |-> (ram_be == 4'h0));

    a_r7_csr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata & ~32'h20) == 32'h0);

    a_r8_other_csr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr != 12'h310) |-> (csr_rdata == 32'h0));

    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !ram_en);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> halt);

    a_r12_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !halt);

    a_r13_load_response: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ls_req && !ls_we) |=> ls_rvalid);

    a_r13_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_rvalid && fetch_rvalid));

    a_r13_fetch_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && ls_req) |-> fetch_stall);
endmodule

bind mem_order_unit mou_checker u_mou_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reload       (reload),
    .fetch_req    (fetch_req),
    .fetch_stall  (fetch_stall),
    .fetch_rvalid (fetch_rvalid),
    .ls_req       (ls_req),
    .ls_we        (ls_we),
    .ls_size      (ls_size),
    .ls_rvalid    (ls_rvalid),
    .csr_addr     (csr_addr),
    .csr_rdata    (csr_rdata),
    .halt         (halt),
    .ram_en       (ram_en),
    .ram_we       (ram_we),
    .ram_be       (ram_be)
);

// File: tb/tb_mem_order_unit.sv
module tb_mem_order_unit;
    localparam int RAM_BYTES = 256;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reload = 1'b0;
    logic [31:0] pc = 32'h0;
    logic fetch_req = 1'b0;
    logic [31:0] fetch_addr = 32'h0;
    logic fetch_stall, fetch_rvalid;
    logic [31:0] fetch_rdata;
    logic ls_req = 1'b0, ls_we = 1'b0;
    logic [1:0] ls_size = 2'd0;
    logic [31:0] ls_addr = 32'h0, ls_wdata = 32'h0;
    logic ls_rvalid;
    logic [31:0] ls_rdata;
    logic csr_we = 1'b0;
    logic [11:0] csr_addr = 12'h310;
    logic [31:0] csr_wdata = 32'h0;
    logic [31:0] csr_rdata;
    logic halt;
    logic [31:0] fault_addr, fault_pc;
    logic ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [3:0] ram_be;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = 32'h0;

    logic [7:0] mem [RAM_BYTES];
    int checks = 0;
    int errors = 0;
    int ram_ops = 0;

    always #2 clk = ~clk;

    mem_order_unit #(.RAM_BYTES(RAM_BYTES)) dut (.*);

    // Byte-lane RAM model: lane k is byte ram_addr+k, read data one cycle later.
    always @(posedge clk) begin
        if (ram_en) begin
            ram_ops <= ram_ops + 1;
            for (int k = 0; k < 4; k++) begin
                if (ram_we && ram_be[k]) mem[(int'(ram_addr) + k) % RAM_BYTES] <= ram_wdata[8*k +: 8];
                ram_rdata[8*k +: 8] <= mem[(int'(ram_addr) + k) % RAM_BYTES];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic set_order(input logic [31:0] val);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 12'h310; csr_wdata = val;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] val);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = val;
        @(negedge clk);
        csr_we = 1'b0; csr_addr = 12'h310;
    endtask

    // Load: request in one cycle, response sampled mid-way through the next.
    task automatic load(input logic [1:0] sz, input logic [31:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        ls_req = 1'b1; ls_we = 1'b0; ls_size = sz; ls_addr = a;
        @(negedge clk);
        ls_req = 1'b0;
        d = ls_rdata; v = ls_rvalid;
    endtask

    task automatic store(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] w);
        @(negedge clk);
        ls_req = 1'b1; ls_we = 1'b1; ls_size = sz; ls_addr = a; ls_wdata = w;
        @(negedge clk);
        ls_req = 1'b0; ls_we = 1'b0;
    endtask

    // {big[3:0], size[3:0], addr[31:0], expected[31:0]}; memory byte at i holds i.
    localparam logic [71:0] VEC [8] = '{
        {4'd0, 4'd0, 32'h21, 32'h00000021},
        {4'd0, 4'd1, 32'h30, 32'h00003130},
        {4'd0, 4'd2, 32'h40, 32'h43424140},
        {4'd0, 4'd2, 32'h42, 32'h45444342},
        {4'd1, 4'd0, 32'h21, 32'h00000021},
        {4'd1, 4'd1, 32'h30, 32'h00003031},
        {4'd1, 4'd2, 32'h40, 32'h40414243},
        {4'd1, 4'd1, 32'h55, 32'h00005556}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic v;
        logic cur_big;
        for (int i = 0; i < RAM_BYTES; i++) mem[i] = 8'(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 csr", csr_rdata, 32'h0);
        check("R1 halt", {31'h0, halt}, 32'h0);
        check("R1 rvalid", {30'h0, ls_rvalid, fetch_rvalid}, 32'h0);

        // R2 / R3 / R7: table walk
        cur_big = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic big;
            big = VEC[i][68];
            if (big != cur_big) begin
                set_order(big ? 32'h20 : 32'h0);
                cur_big = big;
                check("R7 csr read", csr_rdata, big ? 32'h20 : 32'h0);
            end
            load(VEC[i][65:64], VEC[i][63:32], d, v);
            check(big ? "R3 valid" : "R2 valid", {31'h0, v}, 32'h1);
            check(big ? "R3 load" : "R2 load", d, VEC[i][31:0]);
        end

        // R6: fetch is little-endian with the bit set
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 32'h40;
        @(negedge clk);
        fetch_req = 1'b0;
        check("R6 fetch valid", {31'h0, fetch_rvalid}, 32'h1);
        check("R6 fetch", fetch_rdata, 32'h43424140);

        // R4 / R5: big-endian halfword store
        store(2'd1, 32'h80, 32'h1234AABB);
        check("R4 byte A", {24'h0, mem[8'h80]}, 32'hAA);
        check("R4 byte A+1", {24'h0, mem[8'h81]}, 32'hBB);
        check("R5 below", {24'h0, mem[8'h7F]}, 32'h7F);
        check("R5 above", {24'h0, mem[8'h82]}, 32'h82);

        // R7: other bits ignored
        set_order(32'hFFFFFFDF);
        check("R7 other bits", csr_rdata, 32'h0);
        load(2'd2, 32'h80, d, v);
        check("R4 readback LE", d, 32'h8382BBAA);
        store(2'd0, 32'h90, 32'hDDCCBBEE);
        check("R5 byte store", {24'h0, mem[8'h90]}, 32'hEE);
        check("R5 byte neighbour", {24'h0, mem[8'h91]}, 32'h91);
        store(2'd2, 32'hA0, 32'h44332211);
        check("R4 LE word", {mem[8'hA3], mem[8'hA2], mem[8'hA1], mem[8'hA0]}, 32'h44332211);

        // R8: writes to other CSRs change nothing
        csr_write(12'h300, 32'hFFFFFFFF);
        csr_write(12'hC00, 32'hFFFFFFFF);
        csr_write(12'hF11, 32'hFFFFFFFF);
        check("R8 order bit", csr_rdata, 32'h0);
        csr_addr = 12'hC80;
        @(negedge clk);
        check("R8 read zero", csr_rdata, 32'h0);
        csr_addr = 12'h310;
        load(2'd1, 32'h30, d, v);
        check("R8 still LE", d, 32'h3130);

        // R9: write and load in the same cycle
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 32'h20;
        ls_req = 1'b1; ls_we = 1'b0; ls_size = 2'd1; ls_addr = 32'h30;
        @(negedge clk);
        csr_we = 1'b0; ls_req = 1'b0;
        check("R9 same cycle old order", ls_rdata, 32'h3130);
        load(2'd1, 32'h30, d, v);
        check("R9 next access new order", d, 32'h3031);

        // R13: simultaneous data and fetch
        @(negedge clk);
        ls_req = 1'b1; ls_we = 1'b0; ls_size = 2'd0; ls_addr = 32'h21;
        fetch_req = 1'b1; fetch_addr = 32'h40;
        #1 check("R13 stall", {31'h0, fetch_stall}, 32'h1);
        @(negedge clk);
        ls_req = 1'b0; fetch_req = 1'b0;
        check("R13 data served", {30'h0, ls_rvalid, fetch_rvalid}, 32'h2);
        check("R13 data value", ls_rdata, 32'h21);

        // R10: boundary in range, then out of range
        set_order(32'h0);
        load(2'd2, 32'hFC, d, v);
        check("R10 last word ok", d, 32'hFFFEFDFC);
        pc = 32'h00001234;
        set_order(32'h20);
        load(2'd2, 32'hFD, d, v);
        check("R10 no response", {31'h0, v}, 32'h0);
        check("R10 halt", {31'h0, halt}, 32'h1);
        check("R10 fault addr", fault_addr, 32'hFD);
        check("R10 fault pc", fault_pc, 32'h1234);

        // R11: halted unit serves nothing
        begin
            int ops;
            ops = ram_ops;
            store(2'd0, 32'h10, 32'h55);
            load(2'd0, 32'h10, d, v);
            check("R11 no response", {31'h0, v}, 32'h0);
            check("R11 no ram access", ram_ops, ops);
            check("R11 mem intact", {24'h0, mem[8'h10]}, 32'h10);
            check("R11 halt stays", {31'h0, halt}, 32'h1);
        end

        // R12: reload
        @(negedge clk);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        check("R12 halt clear", {31'h0, halt}, 32'h0);
        check("R12 order clear", csr_rdata, 32'h0);
        load(2'd1, 32'h30, d, v);
        check("R12 serves again", d, 32'h3130);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule